// File: doc/BRIEF.md
# Two-Wire Serial Programming Host Sequencer

This block is the host side of a two-wire programming link to a target device. One wire is an interface clock that the host generates. The other is a data line that the host and the target take turns driving. A request port hands the block one operation at a time, together with a 14-bit word. The operations are: load a word into configuration space, program memory or data memory; read back from program or data memory; increment the target address; start or stop a programming cycle; and bulk erase. The block sends a 6-bit command code least significant bit first. Load and read operations then get a 16-slot data frame after it: a start slot, 14 payload bits least significant bit first, and a stop slot.

The host changes the data line only at a rising edge of the interface clock, and the target latches it on the falling edge. A read frame hands the line to the target from the second rising edge of the frame to its end. The host drops its output enable for that window and samples the target's bit just before each falling edge. The interface clock is held low for a parameterised number of system clocks between a command and its frame, and again after each operation, so that the minimum spacing between frames is met. A begin-programming operation also waits for a number of system clocks taken from the request word. A one-cycle done strobe ends every operation, and the gathered read word is presented with it.

Top module: `serprog_host`

## Requirements
- R1: During and just after reset, req_ready is 1, done is 0, pgm_clk is 0, pgm_dout is 0, pgm_oe is 1 and rd_data is 0.
- R2: Each accepted operation sends 6 interface clock cycles carrying its command code LSb first. The operation codes on req_op map to command codes as follows: 0 to 0x00, 1 to 0x02, 2 to 0x03, 3 to 0x04, 4 to 0x05, 5 to 0x06, 6 to 0x08, 7 to 0x18, 8 to 0x0A, 9 to 0x09, 10 to 0x0B. Each interface clock cycle is HALF system clocks high followed by HALF low. pgm_dout changes only at a rising edge of pgm_clk.
- R3: Operations 0 to 4 follow the command with a 16-cycle frame. Slot 0 is a start slot driven 0. For loads, slots 1 to 14 carry the payload LSb first, and slot 15 is a stop slot driven 0.
- R4: pgm_clk stays low for exactly HALF + GAP system clocks between the last falling edge of a command and the first rising edge of its frame.
- R5: A data-memory load (op 2) sends req_data[7:0] in payload slots 1 to 8 and zeros in slots 9 to 14.
- R6: During a read frame (op 3 or 4), pgm_oe is 0 from the rising edge of slot 1 to the end of the frame and 1 at every other rising edge. pgm_din is sampled at the end of the high phase of slots 1 to 14, and those bits land in rd_data bits 0 to 13 in that order.
- R7: A data-memory read (op 4) returns zeros in rd_data[13:8].
- R8: The begin operations (op 6 and 7) hold the link idle for req_data + 1 system clocks after the command, before the closing gap.
- R9: The done strobe lasts one cycle. It comes N + 1 clocks after the accepting edge, where N = 12·HALF + GAP, plus GAP + 32·HALF for ops 0 to 4, plus req_data + 1 for ops 6 and 7. req_ready is 0 from acceptance through done, and req_valid is ignored while it is 0.
- R10: Operations 5 and 8 to 10 send only the 6-cycle command, with no frame.
- R11: Operation codes 11 to 15 are accepted with no activity on pgm_clk. done follows on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | High while idle; a request is taken when both are high |
| req_op | input | 4 | Operation code |
| req_data | input | 14 | Load word, or wait length for begin operations |
| done | output | 1 | One-cycle end-of-operation strobe |
| rd_data | output | 14 | Word gathered by the last read frame |
| pgm_clk | output | 1 | Interface clock to the target |
| pgm_dout | output | 1 | Host data toward the target |
| pgm_oe | output | 1 | Output enable for the host data driver |
| pgm_din | input | 1 | Data line as seen from the target |

## Verification
Every result is timed from the clock edge that accepts the request. The done strobe is due N + 1 clocks after that edge, N being the sum in R9. The bench counts falling clock edges from acceptance and checks that done arrives at exactly that count. Interface-line results are not timed in system clocks. They are tied to pgm_clk transitions, which the bench finds by comparing each falling-edge sample with the one before. Bits are captured at each falling edge of pgm_clk. Output enable and target data are checked and driven at each rising edge. The gap is measured as the distance between the last command falling edge and the first frame rising edge.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

  localparam int CMD_W  = 6;
  localparam int PAY_W  = 14;
  localparam int FRM_W  = PAY_W + 2;
  localparam int IMG_W  = CMD_W + FRM_W;
  localparam int DMEM_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_GAP1, ST_DATA, ST_WAIT, ST_GAP2, ST_DONE
  } st_e;

  function automatic logic op_known(input logic [3:0] op);
    return op <= 4'd10;
  endfunction

  function automatic logic op_has_frame(input logic [3:0] op);
    return op <= 4'd4;
  endfunction

  function automatic logic op_is_read(input logic [3:0] op);
    return (op == 4'd3) || (op == 4'd4);
  endfunction

  function automatic logic op_is_dmem(input logic [3:0] op);
    return (op == 4'd2) || (op == 4'd4);
  endfunction

  function automatic logic op_is_begin(input logic [3:0] op);
    return (op == 4'd6) || (op == 4'd7);
  endfunction

  function automatic logic [CMD_W-1:0] cmd_code(input logic [3:0] op);
    case (op)
      4'd0:    return 6'h00;
      4'd1:    return 6'h02;
      4'd2:    return 6'h03;
      4'd3:    return 6'h04;
      4'd4:    return 6'h05;
      4'd5:    return 6'h06;
      4'd6:    return 6'h08;
      4'd7:    return 6'h18;
      4'd8:    return 6'h0A;
      4'd9:    return 6'h09;
      4'd10:   return 6'h0B;
      default: return 6'h00;
    endcase
  endfunction

  // Whole serial image, bit 0 leaves first: command, start, payload, stop.
  function automatic logic [IMG_W-1:0] tx_image(input logic [3:0] op,
                                                input logic [PAY_W-1:0] word);
    logic [PAY_W-1:0] pay;
    pay = op_is_dmem(op) ? {{(PAY_W-DMEM_W){1'b0}}, word[DMEM_W-1:0]} : word;
    return {1'b0, pay, 1'b0, cmd_code(op)};
  endfunction

endpackage

// File: rtl/serprog_bitclk.sv
module serprog_bitclk #(
  parameter int HALF = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bit_end,
  output logic samp,
  output logic phase_hi
);
  localparam int PER = 2 * HALF;
  localparam int CW  = (PER > 2) ? $clog2(PER) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run)                cnt <= '0;
    else if (cnt == CW'(PER - 1)) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign bit_end  = run && (cnt == CW'(PER - 1));
  assign samp     = run && (cnt == CW'(HALF - 1));
  assign phase_hi = run && (cnt < CW'(HALF));

  // R2: every bit period ends in the low phase
  assert_end_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> !phase_hi);
endmodule

// File: rtl/serprog_shift.sv
module serprog_shift
  import serprog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IMG_W-1:0] img,
  input  logic             shift,
  input  logic             capture,
  input  logic             din,
  output logic             tx_bit,
  output logic [PAY_W-1:0] rx
);
  logic [IMG_W-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx <= '0;
    else if (load)  tx <= img;
    else if (shift) tx <= {1'b0, tx[IMG_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx <= '0;
    else if (capture) rx <= {din, rx[PAY_W-1:1]};
  end

  assign tx_bit = tx[0];
endmodule

// File: rtl/serprog_fsm.sv
module serprog_fsm
  import serprog_pkg::*;
#(
  parameter int GAP = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       req_op,
  input  logic [PAY_W-1:0] req_data,
  input  logic             bit_end,
  output logic             req_ready,
  output logic             accept,
  output st_e              st,
  output logic [4:0]       bit_idx,
  output logic [3:0]       op_q
);
  localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam int CW = (GW > PAY_W) ? GW : PAY_W;
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP - 1);
  localparam logic [4:0]    CMD_LAST = 5'(CMD_W - 1);
  localparam logic [4:0]    FRM_LAST = 5'(FRM_W - 1);

  logic [CW-1:0]    wcnt;
  logic [PAY_W-1:0] wait_q;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_idx <= '0;
      wcnt    <= '0;
      op_q    <= '0;
      wait_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          op_q    <= req_op;
          wait_q  <= req_data;
          bit_idx <= '0;
          wcnt    <= '0;
          st      <= op_known(req_op) ? ST_CMD : ST_DONE;
        end
        ST_CMD: if (bit_end) begin
          if (bit_idx == CMD_LAST) begin
            bit_idx <= '0;
            wcnt    <= '0;
            if (op_has_frame(op_q))     st <= ST_GAP1;
            else if (op_is_begin(op_q)) st <= ST_WAIT;
            else                        st <= ST_GAP2;
          end else bit_idx <= bit_idx + 1'b1;
        end
        ST_GAP1: if (wcnt == GAP_LAST) begin
          wcnt <= '0;
          st   <= ST_DATA;
        end else wcnt <= wcnt + 1'b1;
        ST_DATA: if (bit_end) begin
          if (bit_idx == FRM_LAST) begin
            bit_idx <= '0;
            wcnt    <= '0;
            st      <= ST_GAP2;
          end else bit_idx <= bit_idx + 1'b1;
        end
        ST_WAIT: if (wcnt == CW'(wait_q)) begin
          wcnt <= '0;
          st   <= ST_GAP2;
        end else wcnt <= wcnt + 1'b1;
        ST_GAP2: if (wcnt == GAP_LAST) begin
          wcnt <= '0;
          st   <= ST_DONE;
        end else wcnt <= wcnt + 1'b1;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: completion is a single-cycle state
  assert_done_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) |=> (st == ST_IDLE));
  // R9: an accepted request makes the port busy on the next cycle
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R4: the pre-frame gap leads only into the frame
  assert_gap_to_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP1) |=> (st == ST_GAP1 || st == ST_DATA));
endmodule

// File: rtl/serprog_host.sv
module serprog_host
  import serprog_pkg::*;
#(
  parameter int HALF = 25,
  parameter int GAP  = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [3:0]  req_op,
  input  logic [13:0] req_data,
  output logic        done,
  output logic [13:0] rd_data,
  output logic        pgm_clk,
  output logic        pgm_dout,
  output logic        pgm_oe,
  input  logic        pgm_din
);
  st_e              st;
  logic [4:0]       bit_idx;
  logic [3:0]       op_q;
  logic             accept, run, bit_end, samp, phase_hi, tx_bit;
  logic             rd_phase, capture;
  logic [PAY_W-1:0] rx;

  assign run = (st == ST_CMD) || (st == ST_DATA);

  serprog_fsm #(.GAP(GAP)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_data(req_data), .bit_end(bit_end), .req_ready(req_ready),
    .accept(accept), .st(st), .bit_idx(bit_idx), .op_q(op_q));

  serprog_bitclk #(.HALF(HALF)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .run(run), .bit_end(bit_end),
    .samp(samp), .phase_hi(phase_hi));

  assign rd_phase = (st == ST_DATA) && op_is_read(op_q);
  assign capture  = samp && rd_phase && (bit_idx >= 5'd1) && (bit_idx <= 5'(PAY_W));

  serprog_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .img(tx_image(req_op, req_data)),
    .shift(bit_end), .capture(capture), .din(pgm_din), .tx_bit(tx_bit), .rx(rx));

  assign pgm_clk  = phase_hi;
  assign pgm_dout = run && tx_bit;
  assign pgm_oe   = !(rd_phase && (bit_idx != 5'd0));
  assign done     = (st == ST_DONE);
  assign rd_data  = op_is_dmem(op_q) ? {{(PAY_W-DMEM_W){1'b0}}, rx[DMEM_W-1:0]} : rx;

  // R2: data is held through each high phase, so the falling edge sees a settled bit
  assert_dout_stable_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_clk && $past(pgm_clk)) |-> $stable(pgm_dout));
  // R6: the host lets go of the line only at a rising interface edge
  assert_oe_drop_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgm_oe) |-> $rose(pgm_clk));
  // R6: the host takes the line back only while the interface clock is low
  assert_oe_back_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_oe) |-> !pgm_clk);
  // R9: done is a single-cycle strobe
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/serprog_host_tb.sv
module serprog_host_tb;
  localparam int HALF = 3;
  localparam int GAP  = 5;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0;
  logic [3:0]  req_op = 0;
  logic [13:0] req_data = 0;
  logic        pgm_din = 0;
  logic        req_ready, done, pgm_clk, pgm_dout, pgm_oe;
  logic [13:0] rd_data;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  serprog_host #(.HALF(HALF), .GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .done(done), .rd_data(rd_data),
    .pgm_clk(pgm_clk), .pgm_dout(pgm_dout), .pgm_oe(pgm_oe), .pgm_din(pgm_din));

  // op(4) | request word(14) | word the modelled target returns(14)
  localparam logic [31:0] VEC [12] = '{
    {4'd0,  14'h2A5C, 14'h0000},
    {4'd1,  14'h1357, 14'h0000},
    {4'd2,  14'h3FA5, 14'h0000},
    {4'd3,  14'h0000, 14'h2C3B},
    {4'd4,  14'h0000, 14'h3D96},
    {4'd5,  14'h0000, 14'h0000},
    {4'd6,  14'd9,    14'h0000},
    {4'd7,  14'd0,    14'h0000},
    {4'd8,  14'h0000, 14'h0000},
    {4'd9,  14'h0000, 14'h0000},
    {4'd10, 14'h0000, 14'h0000},
    {4'd13, 14'h0000, 14'h0000}
  };

  function automatic logic [5:0] b_cmd(input logic [3:0] op);
    logic [5:0] t [11] = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06,
                           6'h08, 6'h18, 6'h0A, 6'h09, 6'h0B};
    return (op < 11) ? t[op] : 6'h00;
  endfunction
  function automatic bit b_frame(input logic [3:0] op); return op < 5; endfunction
  function automatic bit b_read (input logic [3:0] op); return op == 3 || op == 4; endfunction
  function automatic bit b_dmem (input logic [3:0] op); return op == 2 || op == 4; endfunction
  function automatic bit b_begin(input logic [3:0] op); return op == 6 || op == 7; endfunction
  function automatic int b_due(input logic [3:0] op, input logic [13:0] d);
    int n;
    if (op > 10) return 1;
    n = 12 * HALF + GAP;
    if (b_frame(op)) n += GAP + 32 * HALF;
    if (b_begin(op)) n += int'(d) + 1;
    return n + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  int          got_k, got_fe, gap_meas, oe_err, stab_err, busy_err, hi_after;
  logic [21:0] got_rx;
  bit          timed_out = 0;

  task automatic run_op(input logic [3:0] op, input logic [13:0] dat,
                        input logic [13:0] word, input bit poke);
    int k, re, lastf;
    logic prev, prev_d;
    got_rx = '0; got_fe = 0; re = 0; lastf = 0; gap_meas = -1;
    oe_err = 0; stab_err = 0; busy_err = 0; got_k = -1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_data = dat;
    @(negedge clk);
    req_valid = 0; prev = 0; prev_d = 0; k = 1;
    forever begin
      if (poke && k == 4) begin req_valid = 1; req_op = 4'd5; end
      if (poke && k == 5) req_valid = 0;
      if (pgm_clk && !prev) begin
        if (re == 6) gap_meas = k - lastf;
        if (b_read(op) && re >= 7 && re <= 21) begin
          if (pgm_oe) oe_err++;
        end else if (!pgm_oe) oe_err++;
        pgm_din = (b_read(op) && re >= 7 && re <= 20) ? word[re-7] : 1'b0;
        re++;
      end
      if (pgm_clk && prev && pgm_dout != prev_d) stab_err++;
      if (!pgm_clk && prev) begin
        if (got_fe < 22) got_rx[got_fe] = pgm_dout;
        got_fe++;
        lastf = k;
      end
      if (req_ready) busy_err++;
      if (done) begin got_k = k; break; end
      if (k > 5000) begin timed_out = 1; break; end
      prev = pgm_clk; prev_d = pgm_dout; k++;
      @(negedge clk);
    end
  endtask

  task automatic check_op(input logic [3:0] op, input logic [13:0] dat, input logic [13:0] word);
    logic [13:0] pay;
    run_op(op, dat, word, 0);
    chk(got_k == b_due(op, dat), b_begin(op) ? "R8 done timing" : "R9 done timing", got_k, b_due(op, dat));
    chk(busy_err == 0, "R9 ready low while busy", busy_err, 0);
    chk(stab_err == 0, "R2 dout stable in high phase", stab_err, 0);
    if (op > 10) begin
      chk(got_fe == 0, "R11 no interface activity", got_fe, 0);
    end else begin
      chk(got_rx[5:0] == b_cmd(op), "R2 command code", got_rx[5:0], b_cmd(op));
      chk(oe_err == 0, "R6 output enable window", oe_err, 0);
      if (b_frame(op)) begin
        chk(got_fe == 22, "R3 frame length", got_fe, 22);
        chk(got_rx[6] == 1'b0, "R3 start slot", got_rx[6], 0);
        chk(gap_meas == HALF + GAP, "R4 command to frame gap", gap_meas, HALF + GAP);
      end else begin
        chk(got_fe == 6, "R10 command only", got_fe, 6);
      end
      if (b_frame(op) && !b_read(op)) begin
        pay = b_dmem(op) ? {6'b0, dat[7:0]} : dat;
        chk(got_rx[20:7] == pay, b_dmem(op) ? "R5 data memory payload" : "R3 payload",
            got_rx[20:7], pay);
        chk(got_rx[21] == 1'b0, "R3 stop slot", got_rx[21], 0);
      end
      if (b_read(op)) begin
        pay = b_dmem(op) ? {6'b0, word[7:0]} : word;
        chk(rd_data == pay, b_dmem(op) ? "R7 data memory read" : "R6 read word", rd_data, pay);
      end
    end
    @(negedge clk);
    chk(done == 0, "R9 done one cycle", done, 0);
  endtask

  initial begin
    #(20 * 200000);
    timed_out = 1;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, held and then just after release
    chk(req_ready == 1 && done == 0 && pgm_clk == 0 && pgm_dout == 0 && pgm_oe == 1 && rd_data == 0,
        "R1 reset outputs", {req_ready, done, pgm_clk, pgm_dout, pgm_oe}, 5'b10001);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && pgm_clk == 0 && pgm_oe == 1 && rd_data == 0,
        "R1 after release", {req_ready, pgm_clk, pgm_oe}, 3'b101);

    for (int i = 0; i < 12; i++)
      check_op(VEC[i][31:28], VEC[i][27:14], VEC[i][13:0]);

    // R6 / R7 corner words
    check_op(4'd3, 14'h0, 14'h3FFF);
    check_op(4'd3, 14'h0, 14'h2001);
    check_op(4'd4, 14'h0, 14'h3F00);
    check_op(4'd2, 14'h3F00, 14'h0);
    check_op(4'd6, 14'd40, 14'h0);

    // R9 request raised while busy is ignored
    run_op(4'd1, 14'h0F0F, 14'h0, 1);
    chk(got_fe == 22 && got_rx[5:0] == 6'h02, "R9 busy request ignored", got_fe, 22);
    hi_after = 0;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (pgm_clk || done) hi_after++;
    end
    chk(hi_after == 0, "R9 no extra operation after busy request", hi_after, 0);

    if (timed_out) chk(0, "watchdog", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule